// File: doc/BRIEF.md
# Instruction Cycle Timing Controller

This block is the control unit of a single-accumulator machine with 16-bit words. A small sequence counter steps through timing states T0 to T6. From the current state and the opcode latched during decode, the block drives the common-bus source select and the load, increment, read and write strobes that the register datapath, the ALU and the memory carry out. Every instruction runs the same three fetch and decode states. The controller then branches four ways at T3 and runs a fixed microsequence for each memory-reference opcode. Each microsequence ends by clearing the counter back to T0.

Register-reference and input/output instructions are not executed here. At T3 the block raises a one-cycle done flag with a bit that tells the two classes apart, and it returns to T0. A halt request is taken only at an instruction boundary. After that the counter stays at T0 and every strobe stays low until reset.

Top module: `instr_seq_ctrl`

## Requirements
- R1: Synchronous active-low reset puts the 3-bit counter (`t_state`) at T0 and clears the halted condition. The counter never goes past 6, and the state after reset shows the T0 strobes.
- R2: At T0 the bus select is 2 (program counter) and `ar_ld` is high. No other strobe is active.
- R3: At T1 the bus select is 7 (memory) and `mem_rd`, `ir_ld` and `pc_inc` are high together.
- R4: At T2 the bus select is 5 (instruction register) and `ar_ld` is high. The clock edge that ends T2 latches `ir_top[2:0]` (instruction bits 14..12) as the opcode and `ir_top[3]` (bit 15) as the indirect flag. Later changes on `ir_top` have no effect until the next T2.
- R5: At T3, with opcode 0 to 6, the indirect flag decides the strobes. If it is set, the block drives bus select 7, `mem_rd` and `ar_ld`. If it is clear, no strobe is active. In both cases the counter goes on to T4.
- R6: At T3 with opcode 7, `exec_done` pulses and `exec_io` equals the indirect flag (0 for register-reference, 1 for I/O). The counter then returns to T0.
- R7: Opcodes 0, 1 and 2 drive bus select 7, `mem_rd` and `dr_ld` at T4. At T5 they drive `ac_ld` with `alu_op` 00, 01 or 10 respectively, and the counter returns to T0. The encoding is 00 for AND, 01 for ADD and 10 for pass-DR, and `alu_op` is 00 whenever `ac_ld` is low.
- R8: Opcode 3 drives bus select 4 (accumulator) and `mem_wr` at T4. Opcode 4 drives bus select 1 (address register) and `pc_ld` at T4. Both return to T0 after T4.
- R9: Opcode 5 drives bus select 2, `mem_wr` and `ar_inc` at T4. At T5 it drives bus select 1 and `pc_ld`, and the counter returns to T0.
- R10: Opcode 6 drives bus select 7, `mem_rd` and `dr_ld` at T4, and `dr_inc` at T5. At T6 it drives bus select 3 (data register) and `mem_wr`, with `pc_inc` equal to `dr_zero`, and the counter returns to T0.
- R11: A halt request is taken only in the last state of an instruction. The controller then holds `t_state` at 0 with every strobe low and bus select 0 until reset. A request in any other state is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ir_top | input | 4 | Instruction register bits 15..12 |
| dr_zero | input | 1 | Data register holds zero |
| halt_req | input | 1 | Stop at the end of the current instruction |
| t_state | output | 3 | Current timing state |
| bus_sel | output | 3 | Common-bus source code |
| ar_ld | output | 1 | Load address register from bus |
| ar_inc | output | 1 | Increment address register |
| pc_ld | output | 1 | Load program counter from bus |
| pc_inc | output | 1 | Increment program counter |
| ir_ld | output | 1 | Load instruction register from bus |
| dr_ld | output | 1 | Load data register from bus |
| dr_inc | output | 1 | Increment data register |
| ac_ld | output | 1 | Load accumulator from ALU |
| alu_op | output | 2 | ALU function for the accumulator load |
| mem_rd | output | 1 | Memory read onto bus |
| mem_wr | output | 1 | Memory write from bus |
| exec_done | output | 1 | Register-reference or I/O instruction reached |
| exec_io | output | 1 | Class of that instruction (1 = I/O) |

## Verification
The hardest point to reach from the ports is the opcode latch. The decode in T3 to T6 must use the value captured at the end of T2, not the live instruction bits. From T3 onward the stimulus therefore drives the bit-inverse of the instruction onto `ir_top`. A design that decodes the live bits would then follow a different microsequence and show wrong strobes. The halt path is the other hard case: the bench raises the request once in a mid-instruction state, where it must be ignored, and once in a final state, where it must be taken.

// File: rtl/seq_ctrl_pkg.sv
// Shared types for the instruction cycle controller.
// Assumes a 3-bit opcode field and an eight-source common bus.
package seq_ctrl_pkg;
    localparam int OP_W  = 3;
    localparam int DEC_N = 1 << OP_W;

    typedef enum logic [2:0] {
        BUS_NONE = 3'd0,
        BUS_AR   = 3'd1,
        BUS_PC   = 3'd2,
        BUS_DR   = 3'd3,
        BUS_AC   = 3'd4,
        BUS_IR   = 3'd5,
        BUS_TR   = 3'd6,
        BUS_MEM  = 3'd7
    } bus_src_e;

    localparam logic [1:0] ALU_AND  = 2'b00;
    localparam logic [1:0] ALU_ADD  = 2'b01;
    localparam logic [1:0] ALU_PASS = 2'b10;

    typedef struct packed {
        bus_src_e   bus_sel;
        logic       ar_ld;
        logic       ar_inc;
        logic       pc_ld;
        logic       pc_inc;
        logic       ir_ld;
        logic       dr_ld;
        logic       dr_inc;
        logic       ac_ld;
        logic [1:0] alu_op;
        logic       mem_rd;
        logic       mem_wr;
        logic       exec_done;
        logic       exec_io;
    } strobes_t;
endpackage

// File: rtl/seq_counter.sv
// Timing-state counter: clears on request, otherwise advances when enabled.
// Assumes the strobe generator asks for a clear in the last state of each instruction.
module seq_counter #(
    parameter int SC_W = 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            adv,
    input  logic            clr,
    output logic [SC_W-1:0] t_q
);
    // Step, clear or hold the timing state.
    always_ff @(posedge clk) begin
        if (!rst_n)   t_q <= '0;
        else if (clr) t_q <= '0;
        else if (adv) t_q <= t_q + 1'b1;
    end

    a_r1_bound: assert property (@(posedge clk) disable iff (!rst_n)
        t_q <= SC_W'(6));
    a_r1_clear: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (t_q == '0));
endmodule

// File: rtl/op_latch.sv
// Captures opcode and indirect flag at decode and drives a one-hot opcode decode.
// Assumes ld is high for exactly the decode state.
module op_latch
    import seq_ctrl_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ld,
    input  logic [OP_W:0]    ir_top,
    output logic [DEC_N-1:0] d_hot,
    output logic             ind
);
    logic [OP_W-1:0] op_q;

    // Capture the opcode field and the indirect bit in the decode state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            op_q <= '0;
            ind  <= 1'b0;
        end else if (ld) begin
            op_q <= ir_top[OP_W-1:0];
            ind  <= ir_top[OP_W];
        end
    end

    for (genvar g = 0; g < DEC_N; g++) begin : g_dec
        assign d_hot[g] = (op_q == OP_W'(g));
    end

    a_r4_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !ld |=> ($stable(d_hot) && $stable(ind)));
endmodule

// File: rtl/strobe_gen.sv
// Maps timing state and decoded opcode to bus select, strobes and counter clear.
// Assumes d_hot is one-hot and valid from T3 on; all outputs are low when en is low.
module strobe_gen
    import seq_ctrl_pkg::*;
#(
    parameter int SC_W = 3
) (
    input  logic             en,
    input  logic [SC_W-1:0]  t,
    input  logic [DEC_N-1:0] d_hot,
    input  logic             ind,
    input  logic             dr_zero,
    output strobes_t         s,
    output logic             sc_clr
);
    logic data_op;
    assign data_op = d_hot[0] | d_hot[1] | d_hot[2];

    // Decode the microoperation set for this state and opcode.
    always_comb begin
        s      = '0;
        sc_clr = 1'b0;
        if (en) begin
            case (int'(t))
                0: begin
                    s.bus_sel = BUS_PC;
                    s.ar_ld   = 1'b1;
                end
                1: begin
                    s.bus_sel = BUS_MEM;
                    s.mem_rd  = 1'b1;
                    s.ir_ld   = 1'b1;
                    s.pc_inc  = 1'b1;
                end
                2: begin
                    s.bus_sel = BUS_IR;
                    s.ar_ld   = 1'b1;
                end
                3: begin
                    if (d_hot[7]) begin
                        s.exec_done = 1'b1;
                        s.exec_io   = ind;
                        sc_clr      = 1'b1;
                    end else if (ind) begin
                        s.bus_sel = BUS_MEM;
                        s.mem_rd  = 1'b1;
                        s.ar_ld   = 1'b1;
                    end
                end
                4: begin
                    if (data_op || d_hot[6]) begin
                        s.bus_sel = BUS_MEM;
                        s.mem_rd  = 1'b1;
                        s.dr_ld   = 1'b1;
                    end else if (d_hot[3]) begin
                        s.bus_sel = BUS_AC;
                        s.mem_wr  = 1'b1;
                        sc_clr    = 1'b1;
                    end else if (d_hot[4]) begin
                        s.bus_sel = BUS_AR;
                        s.pc_ld   = 1'b1;
                        sc_clr    = 1'b1;
                    end else if (d_hot[5]) begin
                        s.bus_sel = BUS_PC;
                        s.mem_wr  = 1'b1;
                        s.ar_inc  = 1'b1;
                    end
                end
                5: begin
                    if (data_op) begin
                        s.ac_ld  = 1'b1;
                        s.alu_op = d_hot[0] ? ALU_AND : (d_hot[1] ? ALU_ADD : ALU_PASS);
                        sc_clr   = 1'b1;
                    end else if (d_hot[5]) begin
                        s.bus_sel = BUS_AR;
                        s.pc_ld   = 1'b1;
                        sc_clr    = 1'b1;
                    end else if (d_hot[6]) begin
                        s.dr_inc = 1'b1;
                    end
                end
                6: begin
                    s.bus_sel = BUS_DR;
                    s.mem_wr  = 1'b1;
                    s.pc_inc  = dr_zero;
                    sc_clr    = 1'b1;
                end
                default: sc_clr = 1'b1;
            endcase
        end
    end
endmodule

// File: rtl/instr_seq_ctrl.sv
// Instruction cycle controller top: counter, opcode latch, strobe decode and halt flag.
// Assumes the datapath applies the strobes on the clock edge that ends each state.
module instr_seq_ctrl
    import seq_ctrl_pkg::*;
#(
    parameter int SC_W = 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [3:0]      ir_top,
    input  logic            dr_zero,
    input  logic            halt_req,
    output logic [SC_W-1:0] t_state,
    output logic [2:0]      bus_sel,
    output logic            ar_ld,
    output logic            ar_inc,
    output logic            pc_ld,
    output logic            pc_inc,
    output logic            ir_ld,
    output logic            dr_ld,
    output logic            dr_inc,
    output logic            ac_ld,
    output logic [1:0]      alu_op,
    output logic            mem_rd,
    output logic            mem_wr,
    output logic            exec_done,
    output logic            exec_io
);
    localparam logic [SC_W-1:0] T_DECODE = SC_W'(2);

    logic             halted_q;
    logic             run;
    logic             sc_clr;
    logic [DEC_N-1:0] d_hot;
    logic             ind;
    strobes_t         s;

    assign run = !halted_q;

    // Enter the halted condition only at an instruction boundary.
    always_ff @(posedge clk) begin
        if (!rst_n)                 halted_q <= 1'b0;
        else if (halt_req && sc_clr) halted_q <= 1'b1;
    end

    seq_counter #(.SC_W(SC_W)) u_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .adv   (run),
        .clr   (sc_clr),
        .t_q   (t_state)
    );

    op_latch u_lat (
        .clk    (clk),
        .rst_n  (rst_n),
        .ld     (run && (t_state == T_DECODE)),
        .ir_top (ir_top),
        .d_hot  (d_hot),
        .ind    (ind)
    );

    strobe_gen #(.SC_W(SC_W)) u_gen (
        .en      (run),
        .t       (t_state),
        .d_hot   (d_hot),
        .ind     (ind),
        .dr_zero (dr_zero),
        .s       (s),
        .sc_clr  (sc_clr)
    );

    assign bus_sel   = s.bus_sel;
    assign ar_ld     = s.ar_ld;
    assign ar_inc    = s.ar_inc;
    assign pc_ld     = s.pc_ld;
    assign pc_inc    = s.pc_inc;
    assign ir_ld     = s.ir_ld;
    assign dr_ld     = s.dr_ld;
    assign dr_inc    = s.dr_inc;
    assign ac_ld     = s.ac_ld;
    assign alu_op    = s.alu_op;
    assign mem_rd    = s.mem_rd;
    assign mem_wr    = s.mem_wr;
    assign exec_done = s.exec_done;
    assign exec_io   = s.exec_io;

    a_r11_hold: assert property (@(posedge clk) disable iff (!rst_n)
        halted_q |=> (halted_q && t_state == '0));
    a_r6_done_return: assert property (@(posedge clk) disable iff (!rst_n)
        exec_done |=> (t_state == '0));
    a_r10_skip_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (pc_inc && t_state == SC_W'(6)) |-> dr_zero);
    a_r3_rd_wr_excl: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_rd && mem_wr));
    a_r8_write_source: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr |-> (bus_sel == 3'd4 || bus_sel == 3'd2 || bus_sel == 3'd3));
    a_r2_load_source: assert property (@(posedge clk) disable iff (!rst_n)
        (ar_ld || pc_ld || ir_ld || dr_ld) |-> (bus_sel != 3'd0));
endmodule

// File: tb/sim_instr_seq_ctrl.sv
module sim_instr_seq_ctrl;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] ir_top = 4'h0;
    logic       dr_zero = 1'b0;
    logic       halt_req = 1'b0;
    logic [2:0] t_state, bus_sel;
    logic       ar_ld, ar_inc, pc_ld, pc_inc, ir_ld, dr_ld, dr_inc, ac_ld;
    logic [1:0] alu_op;
    logic       mem_rd, mem_wr, exec_done, exec_io;

    int tests = 0;
    int fails = 0;
    int cyc   = 0;
    bit done  = 1'b0;

    instr_seq_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .ir_top(ir_top), .dr_zero(dr_zero),
        .halt_req(halt_req), .t_state(t_state), .bus_sel(bus_sel),
        .ar_ld(ar_ld), .ar_inc(ar_inc), .pc_ld(pc_ld), .pc_inc(pc_inc),
        .ir_ld(ir_ld), .dr_ld(dr_ld), .dr_inc(dr_inc), .ac_ld(ac_ld),
        .alu_op(alu_op), .mem_rd(mem_rd), .mem_wr(mem_wr),
        .exec_done(exec_done), .exec_io(exec_io)
    );

    always #10 clk = ~clk;

    logic [19:0] act;
    assign act = {t_state, bus_sel, ar_ld, ar_inc, pc_ld, pc_inc, ir_ld, dr_ld,
                  dr_inc, ac_ld, alu_op, mem_rd, mem_wr, exec_done, exec_io};

    // {dr_zero, instruction word}
    localparam logic [16:0] VECS [11] = '{
        {1'b0, 16'h0123}, {1'b0, 16'h9ABC}, {1'b0, 16'h2456}, {1'b0, 16'hB010},
        {1'b0, 16'h4100}, {1'b0, 16'hD200}, {1'b1, 16'h6300}, {1'b0, 16'hE300},
        {1'b0, 16'h7800}, {1'b1, 16'hF400}, {1'b0, 16'h8800}
    };

    // Expected {bus,ar_ld,ar_inc,pc_ld,pc_inc,ir_ld,dr_ld,dr_inc,ac_ld,alu_op,rd,wr,done,io}
    function automatic logic [16:0] exp_vec(int t, logic [2:0] op, logic i, logic dz);
        logic [2:0] b = 3'd0;
        logic arl = 0, ari = 0, pcl = 0, pci = 0, irl = 0, drl = 0, dri = 0, acl = 0;
        logic [1:0] alu = 2'b00;
        logic rd = 0, wr = 0, dn = 0, io = 0;
        case (t)
            0: begin b = 3'd2; arl = 1; end
            1: begin b = 3'd7; rd = 1; irl = 1; pci = 1; end
            2: begin b = 3'd5; arl = 1; end
            3: if (op == 3'd7) begin dn = 1; io = i; end
               else if (i) begin b = 3'd7; rd = 1; arl = 1; end
            4: case (op)
                   3'd0, 3'd1, 3'd2, 3'd6: begin b = 3'd7; rd = 1; drl = 1; end
                   3'd3: begin b = 3'd4; wr = 1; end
                   3'd4: begin b = 3'd1; pcl = 1; end
                   3'd5: begin b = 3'd2; wr = 1; ari = 1; end
                   default: ;
               endcase
            5: case (op)
                   3'd0: acl = 1;
                   3'd1: begin acl = 1; alu = 2'b01; end
                   3'd2: begin acl = 1; alu = 2'b10; end
                   3'd5: begin b = 3'd1; pcl = 1; end
                   3'd6: dri = 1;
                   default: ;
               endcase
            6: begin b = 3'd3; wr = 1; pci = dz; end
            default: ;
        endcase
        return {b, arl, ari, pcl, pci, irl, drl, dri, acl, alu, rd, wr, dn, io};
    endfunction

    function automatic int last_t(logic [2:0] op);
        case (op)
            3'd7: return 3;
            3'd3, 3'd4: return 4;
            3'd6: return 6;
            default: return 5;
        endcase
    endfunction

    function automatic string tag_of(int t, logic [2:0] op);
        if (t == 0) return "R2";
        if (t == 1) return "R3";
        if (t == 2) return "R4";
        if (t == 3) return (op == 3'd7) ? "R6" : "R5";
        case (op)
            3'd0, 3'd1, 3'd2: return "R7";
            3'd3, 3'd4: return "R8";
            3'd5: return "R9";
            default: return "R10";
        endcase
    endfunction

    task automatic check(string tag, logic [19:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    // mode 0: plain, 1: halt request in last state, 2: halt request pulse at T1
    task automatic run_instr(logic [15:0] ir, logic dz, int mode);
        logic [2:0] op = ir[14:12];
        int lt = last_t(ir[14:12]);
        ir_top  = ir[15:12];
        dr_zero = dz;
        for (int t = 0; t <= lt; t++) begin
            check(tag_of(t, op), {3'(t), exp_vec(t, op, ir[15], dz)});
            if (t == 3) ir_top = ~ir[15:12];   // R4: latched opcode must be used
            if (mode == 2 && t == 1) halt_req = 1'b1;
            if (mode == 2 && t == 2) halt_req = 1'b0;
            if (mode == 1 && t == lt) halt_req = 1'b1;
            @(negedge clk);
        end
        halt_req = 1'b0;
    endtask

    initial begin
        repeat (2) @(negedge clk);
        check("R1", {3'd0, exp_vec(0, 3'd0, 1'b0, 1'b0)});
        rst_n = 1'b1;
        for (int k = 0; k < 11; k++) run_instr(VECS[k][15:0], VECS[k][16], 0);
        // R11: request in a middle state is ignored; the next instruction runs
        run_instr(16'h1050, 1'b0, 2);
        run_instr(16'h3060, 1'b0, 0);
        // R11: request in the last state stops the controller
        run_instr(16'h2070, 1'b0, 1);
        for (int k = 0; k < 3; k++) begin
            check("R11", 20'd0);
            @(negedge clk);
        end
        // R11 at the end of a register-reference instruction after a reset (R1)
        rst_n = 1'b0;
        @(negedge clk);
        check("R1", {3'd0, exp_vec(0, 3'd0, 1'b0, 1'b0)});
        rst_n = 1'b1;
        run_instr(16'h7001, 1'b0, 1);
        check("R11", 20'd0);
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        run_instr(16'hC400, 1'b0, 0);
        run_instr(16'h6111, 1'b0, 0);
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 20000 && !done) begin
            done = 1'b1;
            tests++;
            fails++;
            $display("FAIL watchdog act=%h exp=finished", act);
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end
endmodule